// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Memory Banks

The block fetches a vector of words from an interleaved read-only memory split into a power-of-two number of banks. A single start pulse supplies a base word address, a constant stride and an element count of up to 64. The engine then generates the addresses base, base+stride, base+2·stride and so on, and tries to issue one request per clock. The bank for each address is taken from its low address bits.

Every access leaves its bank resting for a fixed number of cycles. A request whose bank is still resting is held, and the whole stream waits behind it, so the elements always leave in address-sequence order. Loaded words appear one at a time with a valid flag. A one-cycle completion pulse follows the last word. A counter reports how many cycles the last load lost to bank conflicts. Strides that keep returning to one bank therefore show up directly as lost cycles, while odd strides run at one element per clock.

Top module: `strided_load_unit`

## Requirements
- R1: Element k of a load is read from word address (base + k·stride) mod 2^ADDR_W, and elements are delivered strictly in increasing k. The memory word at address a holds (37·a + 5) mod 2^DATA_W after reset.
- R2: The bank serving address a is a mod NUM_BANKS, taken from the low log2(NUM_BANKS) address bits. The row inside that bank is given by the remaining upper bits.
- R3: After an access in cycle t, the same bank is not accessed again before cycle t + BUSY_CYCLES. A request to a resting bank is held, and no later element overtakes it.
- R4: With no conflicts, element k is presented with its valid flag after the (k+1)-th rising edge following the edge that samples start. Each held cycle delays this element and all later ones by one cycle.
- R5: With an odd stride, NUM_BANKS = 16 and BUSY_CYCLES = 4, a load never loses a cycle. For the default parameters, a load of n elements therefore completes in n+1 edges after the start edge.
- R6: With a stride that is a multiple of NUM_BANKS, every element after the first waits BUSY_CYCLES−1 cycles. A load of n elements thus loses (n−1)·(BUSY_CYCLES−1) cycles.
- R7: `done` is high for exactly one cycle, the cycle right after the last element's valid cycle. With a length of 0, `done` rises on the first edge after the start edge and no element is delivered.
- R8: `stall_cycles` is cleared when a load starts, counts every cycle a request is held, and keeps its value while idle until the next start.
- R9: A `start` pulse while `busy` is high is ignored. The running load delivers exactly its own elements, unchanged.
- R10: After reset, `busy`, `done` and `elem_valid` are low and `stall_cycles` is zero.
- R11: A requested length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (sampled while idle) |
| base_addr | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Constant address step between elements (wraps) |
| length | input | LEN_W | Element count, 0..64 (larger clamps to 64) |
| busy | output | 1 | A load is in progress |
| elem_valid | output | 1 | `elem_data` holds the next element |
| elem_data | output | DATA_W | Loaded word |
| done | output | 1 | One-cycle pulse after the last element |
| stall_cycles | output | STALL_W | Cycles lost to bank conflicts in the last load |

## Verification
A bank timer stuck busy or released early changes the number of held cycles. That error appears in the same load as a wrong `stall_cycles` value and a wrong start-to-done cycle count, and a too-early release also breaks the rest-time property at the next access to that bank. A faulty address step or bank/row split shows up at the first affected element as a word that does not match the address formula. Control faults such as a lost final element, a skipped hold or an accepted restart shift or corrupt the ordered element stream that the scoreboard compares word by word.

// File: rtl/slu_pkg.sv
package slu_pkg;
  // Strobes from control to datapath, valid in the current cycle.
  typedef struct packed {
    logic load;   // capture base address
    logic issue;  // access the target bank and advance the address
  } slu_strobe_t;
endpackage

// File: rtl/slu_datapath.sv
module slu_datapath
  import slu_pkg::*;
#(
  parameter int NUM_BANKS   = 16,
  parameter int BUSY_CYCLES = 4,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slu_strobe_t       strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] stride,
  output logic              bankReady,
  output logic              elemValid,
  output logic [DATA_W-1:0] elemData
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int DEPTH  = 1 << ROW_W;
  localparam int TMR_W  = $clog2(BUSY_CYCLES + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [BANK_W-1:0] curBank;
  logic [ROW_W-1:0]  curRow;
  logic [NUM_BANKS-1:0] bankFree;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bankWord;

  assign curBank   = curAddr[BANK_W-1:0];
  assign curRow    = curAddr[ADDR_W-1:BANK_W];
  assign bankReady = bankFree[curBank];

  function automatic logic [DATA_W-1:0] initWord(input int unsigned a);
    return DATA_W'(a * 37 + 5);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curAddr <= '0;
    end else if (strobe.load) begin
      curAddr <= baseAddr;
    end else if (strobe.issue) begin
      curAddr <= curAddr + stride;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TMR_W-1:0]  restTimer;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              hit;

    assign hit         = strobe.issue && (curBank == BANK_W'(b));
    assign bankFree[b] = (restTimer == '0);
    assign bankWord[b] = mem[curRow];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        restTimer <= '0;
      end else if (hit) begin
        restTimer <= TMR_W'(BUSY_CYCLES - 1);
      end else if (restTimer != '0) begin
        restTimer <= restTimer - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) begin
          mem[i] <= initWord(i * NUM_BANKS + b);
        end
      end
    end

    // R3: a bank is only accessed once its rest time has run out
    a_r3_bank_rested: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> restTimer == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elemValid <= 1'b0;
      elemData  <= '0;
    end else begin
      elemValid <= strobe.issue;
      if (strobe.issue) elemData <= bankWord[curBank];
    end
  end

  // R4: each issued request yields a valid element one cycle later
  a_r4_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |=> elemValid);
endmodule

// File: rtl/slu_control.sv
module slu_control
  import slu_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7,
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   length,
  input  logic               bankReady,
  output slu_strobe_t        strobe,
  output logic               busy,
  output logic               done,
  output logic [STALL_W-1:0] stallCycles
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} state_t;

  state_t           state;
  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] lenEff;

  assign lenEff       = (length > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : length;
  assign strobe.load  = (state == ST_IDLE) && start;
  assign strobe.issue = (state == ST_RUN) && bankReady;
  assign busy         = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      remaining   <= '0;
      stallCycles <= '0;
      done        <= 1'b0;
    end else begin
      done <= (state == ST_TAIL);
      case (state)
        ST_IDLE: if (start) begin
          remaining   <= lenEff;
          stallCycles <= '0;
          state       <= (lenEff == '0) ? ST_TAIL : ST_RUN;
        end
        ST_RUN: if (bankReady) begin
          remaining <= remaining - 1'b1;
          if (remaining == LEN_W'(1)) state <= ST_TAIL;
        end else begin
          stallCycles <= stallCycles + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: the conflict count is frozen while idle and not restarted
  a_r8_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(stallCycles));
  // R11: never more than MAX_LEN elements outstanding
  a_r11_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    remaining <= LEN_W'(MAX_LEN));
  // R9: a start while busy does not restart the count
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !strobe.issue) |=> $stable(remaining));
endmodule

// File: rtl/strided_load_unit.sv
module strided_load_unit
  import slu_pkg::*;
#(
  parameter int NUM_BANKS   = 16,
  parameter int BUSY_CYCLES = 4,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int MAX_LEN     = 64,
  parameter int STALL_W     = 16,
  parameter int LEN_W       = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [ADDR_W-1:0]  stride,
  input  logic [LEN_W-1:0]   length,
  output logic               busy,
  output logic               elem_valid,
  output logic [DATA_W-1:0]  elem_data,
  output logic               done,
  output logic [STALL_W-1:0] stall_cycles
);
  slu_strobe_t strobe;
  logic        bankReady;

  slu_control #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .STALL_W(STALL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .length(length),
    .bankReady(bankReady), .strobe(strobe), .busy(busy), .done(done),
    .stallCycles(stall_cycles)
  );

  slu_datapath #(.NUM_BANKS(NUM_BANKS), .BUSY_CYCLES(BUSY_CYCLES),
                 .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .baseAddr(base_addr),
    .stride(stride), .bankReady(bankReady), .elemValid(elem_valid),
    .elemData(elem_data)
  );
endmodule

// File: tb/strided_load_unit_test.sv
`timescale 1ns/1ps
module strided_load_unit_test;
  localparam int NB = 16;
  localparam int BT = 4;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [AW-1:0] strideIn = '0;
  logic [LW-1:0] lengthIn = '0;
  logic busy, elemValid, done;
  logic [DW-1:0] elemData;
  logic [15:0] stallCycles;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string reqTag = "R1";
  logic [DW-1:0] expQ [$];

  always #2.5 clk = ~clk;

  strided_load_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(baseAddr),
    .stride(strideIn), .length(lengthIn), .busy(busy), .elem_valid(elemValid),
    .elem_data(elemData), .done(done), .stall_cycles(stallCycles)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected words as the design presents them (R1, R3 order).
  always @(negedge clk) begin
    if (rst_n && elemValid) begin
      if (expQ.size() == 0) check(reqTag, "unexpected element", elemData, -1);
      else check(reqTag, "element data", elemData, expQ.pop_front());
    end
  end

  // Driver: builds expectations from the address formula and a bank model.
  task automatic runLoad(input string req, input int base, input int strd,
                         input int len, input bit poke);
    int n, t, stalls, cyc, addr, bank, at;
    int freeAt [NB];
    n = (len > 64) ? 64 : len;                    // R11 clamp
    for (int b = 0; b < NB; b++) freeAt[b] = 0;
    t = 0; stalls = 0;
    for (int k = 0; k < n; k++) begin
      addr = (base + k * strd) % (1 << AW);       // R1 address
      bank = addr % NB;                           // R2 bank select
      at = (freeAt[bank] > t) ? freeAt[bank] : t; // R3 rest time
      stalls += at - t;
      freeAt[bank] = at + BT;
      t = at + 1;
      expQ.push_back(DW'(addr * 37 + 5));
    end
    reqTag = req;
    @(negedge clk);
    baseAddr = AW'(base); strideIn = AW'(strd); lengthIn = LW'(len); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      if (poke && cyc == 2) begin
        start = 1'b1; baseAddr = AW'(base + 7); lengthIn = LW'(3);
      end
      @(posedge clk); cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    check(req, "edges start->done (R4/R7)", cyc, n + 1 + stalls);
    check(req, "stall count (R8)", stallCycles, stalls);
    @(negedge clk);
    check(req, "done one cycle (R7)", done, 0);
    repeat (5) @(negedge clk);
    check(req, "queue drained", expQ.size(), 0);
    check(req, "stall count held idle (R8)", stallCycles, stalls);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "busy", busy, 0);
    check("R10", "done", done, 0);
    check("R10", "elem_valid", elemValid, 0);
    check("R10", "stall_cycles", stallCycles, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    runLoad("R5", 0, 1, 16, 0);      // unit stride, no stalls
    check("R5", "unit stride no stall", stallCycles, 0);
    runLoad("R6", 5, 16, 8, 0);      // stride = bank count
    check("R6", "same-bank loss", stallCycles, 7 * (BT - 1));
    runLoad("R6", 3, 32, 5, 0);      // multiple of bank count
    check("R6", "same-bank loss x2", stallCycles, 4 * (BT - 1));
    runLoad("R1", 1000, 3, 64, 0);   // odd stride with address wrap
    check("R5", "odd stride no stall", stallCycles, 0);
    runLoad("R3", 2, 8, 10, 0);      // two banks alternate
    runLoad("R2", 9, 4, 12, 0);      // four banks, gap equals rest time
    check("R2", "stride 4 no stall", stallCycles, 0);
    runLoad("R7", 12, 1, 0, 0);      // zero length
    runLoad("R11", 40, 1, 100, 0);   // clamp to 64
    runLoad("R9", 100, 2, 20, 1);    // start while busy ignored
    runLoad("R3", 1023, 1023, 9, 0); // stride -1 wraps backwards

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule